// File: doc/BRIEF.md
# Multi-Mode Parallel Host Bus Slave Port

This block lets an external microcontroller read and write an internal register file over an 8-bit parallel bus. Two strap inputs choose the bus style. In the first style, address and data come on separate buses and no latch pulse is used. In the second, the buses are separate and the address is captured by a latch pulse. In the third, address and data share one set of lines. The fourth strap code hands the host pins to a serial interface, and this port then stays silent.

The host control lines are chip select, write strobe, read strobe and address latch. They arrive asynchronously and pass through a two-flop synchroniser. Each falling strobe edge, seen while the port is selected, starts exactly one request on a simple internal request/acknowledge port. The ready output holds the host cycle for as long as that request waits for its acknowledge. During a read the port drives the returned data only while the read strobe is low. Pad tristates appear as separate output-enable signals.

The host must keep a whole access cycle at least 4 system clocks long when ready is never driven, and at least 7 when it is. The address must stay stable for 3 clocks after the latch pulse ends, and a strobe must stay low until ready is released.

Top module: `hostbus_port`

## Requirements
- R1: With strap code 2'b11 the port is disabled: no request is issued, and neither the data bus enable nor the ready enable is ever asserted, whatever the host lines do.
- R2: While chip select (active low) is high, write strobes, read strobes and latch pulses have no effect: no request is issued and the latched address is kept.
- R3: With strap code 2'b00 the request address is the value on the address input when the strobe edge is detected.
- R4: With strap code 2'b01 the address is taken from the address input during the clocks in which the synchronised latch pulse is high. Later changes on the address input do not alter it.
- R5: With strap code 2'b10 the address is taken from the shared data lines while the synchronised latch pulse is high. The same lines then carry the write data.
- R6: Each falling strobe edge while selected issues exactly one request. The request holds its address, direction and write data steady until the acknowledge arrives, and it drops in the clock after the acknowledge.
- R7: A write issues a request with the direction bit set to 1 and with the write data equal to the data bus value held during the strobe.
- R8: A read issues a request with the direction bit set to 0. Once acknowledged, the returned data appears on the data output. The data enable is high only while the synchronised read strobe is low and chip select is low.
- R9: Ready is driven low (enable 1, level 0) from the start of a request until its acknowledge. After that the enable returns to 0 and the level reads 1.
- R10: After reset there is no request, the data enable and ready enable are 0, and the ready level is 1.
- R11: In the two latch modes, a strobe with no new latch pulse reuses the address from the last latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Bus style strap: 00 separate, 01 separate with latch, 10 shared, 11 port off |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ale | input | 1 | Address latch pulse, active high |
| addr_in | input | ADDR_W | Host address bus (separate modes) |
| data_in | input | DATA_W | Host data bus, input side (address too in shared mode) |
| data_out | output | DATA_W | Host data bus, output side |
| data_oe | output | 1 | Drive enable for data_out |
| rdy_o | output | 1 | Ready level: 0 while an access is pending |
| rdy_oe | output | 1 | Drive enable for the ready pin |
| req | output | 1 | Internal access request |
| req_we | output | 1 | Request direction, 1 for write |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Request write data |
| req_rdata | input | DATA_W | Read data from the register file, valid with ack |
| ack | input | 1 | Access complete from the register file |

## Verification
The checker follows the request handshake on every clock. It confirms that a request keeps its fields until it is acknowledged, and that it and ready both drop right after the acknowledge. It confirms that every new request follows a selected strobe three clocks earlier, and that write data and the address in the separate-bus mode match the bus at detection. It also confirms that the data enable follows the delayed read strobe and chip select, and that the disabled mode stays silent. The directed scenarios cover the behaviour that spans whole transactions: addresses held across latch pulses and bursts, data returned by a register file that acknowledges after a random delay, and deselected strobes and latch pulses that have no effect.

// File: rtl/hostbus_pkg.sv
// Shared types for the host bus port.
// Assumes: the strap encoding below is fixed by the board and stable after reset.
package hostbus_pkg;

    typedef enum logic [1:0] {
        BUS_SPLIT       = 2'b00,
        BUS_SPLIT_LATCH = 2'b01,
        BUS_SHARED      = 2'b10,
        BUS_OFF         = 2'b11
    } bus_style_e;

    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_WAIT = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/hostbus_sync.sv
// Two-flop synchroniser for a vector of asynchronous host control lines.
// Assumes: each bit is an independent level; reset loads the idle level of every bit.
module hostbus_sync #(
    parameter int                WIDTH   = 4,
    parameter logic [WIDTH-1:0]  IDLE_LV = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;

    // Purpose: two register stages per line to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= IDLE_LV;
            sync_o <= IDLE_LV;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/hostbus_strobe_dec.sv
// Turns the synchronised host lines into single-cycle start pulses, a latch
// enable and the read drive window.
// Assumes: inputs are already synchronised; port off mode masks everything.
module hostbus_strobe_dec
    import hostbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_style_e style,
    input  logic       cs_n_s,
    input  logic       wr_n_s,
    input  logic       rd_n_s,
    input  logic       ale_s,
    output logic       wr_start,
    output logic       rd_start,
    output logic       latch_en,
    output logic       rd_window
);
    logic wr_n_d;
    logic rd_n_d;
    logic selected;
    logic uses_latch;

    // Purpose: remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_d <= 1'b1;
            rd_n_d <= 1'b1;
        end else begin
            wr_n_d <= wr_n_s;
            rd_n_d <= rd_n_s;
        end
    end

    // Purpose: qualify edges and the latch pulse with chip select and mode.
    always_comb begin
        selected   = (style != BUS_OFF) && !cs_n_s;
        uses_latch = (style == BUS_SPLIT_LATCH) || (style == BUS_SHARED);
        wr_start   = selected && wr_n_d && !wr_n_s;
        rd_start   = selected && rd_n_d && !rd_n_s && !wr_start;
        latch_en   = selected && uses_latch && ale_s;
        rd_window  = selected && !rd_n_s;
    end
endmodule

// File: rtl/hostbus_addr_cap.sv
// Selects the request address for the active bus style: straight from the
// address bus, or from a register loaded by the latch pulse.
// Assumes: in shared mode the address rides on the low ADDR_W data lines.
module hostbus_addr_cap
    import hostbus_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_style_e        style,
    input  logic              latch_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] shared_addr;
    logic [ADDR_W-1:0] held_addr;

    // Purpose: map the shared data lines onto an address of ADDR_W bits.
    generate
        if (ADDR_W <= DATA_W) begin : g_narrow
            assign shared_addr = data_in[ADDR_W-1:0];
        end else begin : g_wide
            assign shared_addr = {{(ADDR_W-DATA_W){1'b0}}, data_in};
        end
    endgenerate

    // Purpose: load the held address during each clock of the latch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
        end else if (latch_en) begin
            held_addr <= (style == BUS_SHARED) ? shared_addr : addr_in;
        end
    end

    // Purpose: the latch-free style reads the address bus live.
    always_comb begin
        cur_addr = (style == BUS_SPLIT) ? addr_in : held_addr;
    end
endmodule

// File: rtl/hostbus_xfer.sv
// Runs one internal access per start pulse, holds ready low until the ack and
// keeps read data for the host while the read strobe stays low.
// Assumes: ack is only meaningful while req is high.
module hostbus_xfer
    import hostbus_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              rd_start,
    input  logic              rd_window,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] req_rdata,
    input  logic              ack,
    output logic              req,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_o,
    output logic              rdy_oe
);
    xfer_state_e       state;
    logic [DATA_W-1:0] rd_hold;
    logic              rd_ready;

    // Purpose: request sequencing and capture of request fields and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= XFER_IDLE;
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            rd_hold   <= '0;
            rd_ready  <= 1'b0;
        end else begin
            if (!rd_window) begin
                rd_ready <= 1'b0;
            end
            case (state)
                XFER_IDLE: begin
                    if (wr_start || rd_start) begin
                        state     <= XFER_WAIT;
                        req_we    <= wr_start;
                        req_addr  <= cur_addr;
                        req_wdata <= data_in;
                        rd_ready  <= 1'b0;
                    end
                end
                XFER_WAIT: begin
                    if (ack) begin
                        state <= XFER_IDLE;
                        if (!req_we) begin
                            rd_hold  <= req_rdata;
                            rd_ready <= rd_window;
                        end
                    end
                end
                default: state <= XFER_IDLE;
            endcase
        end
    end

    // Purpose: drive request, ready and data enables from the state.
    always_comb begin
        req      = (state == XFER_WAIT);
        rdy_oe   = (state == XFER_WAIT);
        rdy_o    = (state != XFER_WAIT);
        data_out = rd_hold;
        data_oe  = rd_ready && rd_window;
    end
endmodule

// File: rtl/hostbus_port.sv
// Top of the multi-mode host bus slave port: synchronises the host lines,
// decodes strobes, captures the address and runs the internal access.
// Assumes: mode_sel is a strap, stable while out of reset.
module hostbus_port
    import hostbus_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_o,
    output logic              rdy_oe,
    output logic              req,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_rdata,
    input  logic              ack
);
    localparam int CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1110;

    bus_style_e        style;
    logic [CTRL_W-1:0] ctrl_s;
    logic              wr_start;
    logic              rd_start;
    logic              latch_en;
    logic              rd_window;
    logic [ADDR_W-1:0] cur_addr;

    assign style = bus_style_e'(mode_sel);

    hostbus_sync #(.WIDTH(CTRL_W), .IDLE_LV(CTRL_IDLE)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, wr_n, rd_n, ale}),
        .sync_o  (ctrl_s)
    );

    hostbus_strobe_dec dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .style     (style),
        .cs_n_s    (ctrl_s[3]),
        .wr_n_s    (ctrl_s[2]),
        .rd_n_s    (ctrl_s[1]),
        .ale_s     (ctrl_s[0]),
        .wr_start  (wr_start),
        .rd_start  (rd_start),
        .latch_en  (latch_en),
        .rd_window (rd_window)
    );

    hostbus_addr_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .style    (style),
        .latch_en (latch_en),
        .addr_in  (addr_in),
        .data_in  (data_in),
        .cur_addr (cur_addr)
    );

    hostbus_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) xfer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_start  (wr_start),
        .rd_start  (rd_start),
        .rd_window (rd_window),
        .cur_addr  (cur_addr),
        .data_in   (data_in),
        .req_rdata (req_rdata),
        .ack       (ack),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .rdy_o     (rdy_o),
        .rdy_oe    (rdy_oe)
    );
endmodule

// File: rtl/hostbus_port_chk.sv
// Clocked property checker for hostbus_port, attached by bind.
// Assumes: the two synchroniser stages plus one decode register give a
// three-clock path from a host line to a new request.
module hostbus_port_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              cs_n,
    input logic              wr_n,
    input logic              rd_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [DATA_W-1:0] data_in,
    input logic              data_oe,
    input logic              rdy_o,
    input logic              rdy_oe,
    input logic              req,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              ack
);
    a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> (!req && !data_oe && !rdy_oe));

    a_r2_selected_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (!$past(cs_n, 3) && (!$past(wr_n, 3) || !$past(rd_n, 3))));

    a_r3_split_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req) && mode_sel == 2'b00) |-> (req_addr == $past(addr_in)));

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_we) && $stable(req_addr) && $stable(req_wdata)));

    a_r6_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

    a_r7_wdata: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req) && req_we) |-> (req_wdata == $past(data_in)));

    a_r8_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!$past(rd_n, 2) && !$past(cs_n, 2)));

    a_r9_ready_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (rdy_oe && !rdy_o));

    a_r9_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> (!rdy_oe && rdy_o));
endmodule

bind hostbus_port hostbus_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .addr_in   (addr_in),
    .data_in   (data_in),
    .data_oe   (data_oe),
    .rdy_o     (rdy_o),
    .rdy_oe    (rdy_oe),
    .req       (req),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ack       (ack)
);

// File: tb/hostbus_port_tb_top.sv
`timescale 1ns/1ps
module hostbus_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       ale = 1'b0;
    logic [7:0] addr_in = 8'h00;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       rdy_o;
    logic       rdy_oe;
    logic       req;
    logic       req_we;
    logic [7:0] req_addr;
    logic [7:0] req_wdata;
    logic [7:0] req_rdata = 8'h00;
    logic       ack = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // register file model state
    logic [7:0] rf [256];
    logic [7:0] exp_mem [256];
    int         rf_wait = 0;
    int         req_count = 0;
    logic [7:0] last_addr = 8'h00;
    logic       last_we = 1'b0;
    logic [7:0] last_wdata = 8'h00;

    always #2 clk = ~clk;

    hostbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .ale(ale), .addr_in(addr_in), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .rdy_o(rdy_o), .rdy_oe(rdy_oe),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .ack(ack)
    );

    // register file with a random acknowledge delay of 0..5 clocks
    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else if (ack) begin
            ack <= 1'b0;
        end else if (req) begin
            if (rf_wait == 0) begin
                ack        <= 1'b1;
                req_rdata  <= rf[req_addr];
                if (req_we) rf[req_addr] <= req_wdata;
                req_count  <= req_count + 1;
                last_addr  <= req_addr;
                last_we    <= req_we;
                last_wdata <= req_wdata;
                rf_wait    <= $urandom_range(0, 5);
            end else begin
                rf_wait <= rf_wait - 1;
            end
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ale = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // one host access; latch modes pulse the latch only when do_latch is set
    task automatic host_access(input bit is_wr, input bit do_latch, input logic [7:0] a,
                               input logic [7:0] d, input string tag);
        int  base;
        bit  saw_rdy = 0;
        bit  finished = 0;
        @(negedge clk);
        cs_n = 1'b0;
        if (mode_sel != 2'b00 && do_latch) begin
            if (mode_sel == 2'b01) addr_in = a; else data_in = a;
            ale = 1'b1;
            repeat (3) @(negedge clk);
            ale = 1'b0;
            repeat (3) @(negedge clk);
        end
        if (mode_sel == 2'b00) addr_in = a;
        if (mode_sel == 2'b01) addr_in = ~a;   // R4: later bus changes must not matter
        data_in = is_wr ? d : 8'h00;
        base = req_count;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (rdy_oe && !rdy_o) saw_rdy = 1;
            if (req_count != base && !rdy_oe) begin
                finished = 1;
                break;
            end
        end
        check_eq({tag, " R6 access completed"}, finished, 1);
        check_eq({tag, " R9 ready driven low while pending"}, saw_rdy, 1);
        check_eq({tag, " R9 ready released"}, {rdy_oe, rdy_o}, 2'b01);
        check_eq({tag, " R3/R4/R5/R11 request address"}, last_addr, a);
        check_eq({tag, " R7/R8 direction"}, last_we, is_wr);
        if (is_wr) begin
            check_eq({tag, " R7 write data"}, last_wdata, d);
            exp_mem[a] = d;
            wr_n = 1'b1;
        end else begin
            check_eq({tag, " R8 data enabled during strobe"}, data_oe, 1);
            check_eq({tag, " R8 read data"}, data_out, exp_mem[a]);
            rd_n = 1'b1;
            repeat (3) @(negedge clk);
            check_eq({tag, " R8 data released after strobe"}, data_oe, 0);
        end
        repeat (4) @(negedge clk);
        check_eq({tag, " R6 exactly one request"}, req_count, base + 1);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    // strobes with the port quiet; nothing must reach the internal side
    task automatic quiet_strobes(input bit sel, input string tag);
        int  base = req_count;
        bit  seen = 0;
        @(negedge clk);
        cs_n = sel ? 1'b0 : 1'b1;
        wr_n = 1'b0;
        for (int n = 0; n < 8; n++) begin @(negedge clk); if (req || rdy_oe || data_oe) seen = 1; end
        wr_n = 1'b1;
        for (int n = 0; n < 4; n++) begin @(negedge clk); if (req || rdy_oe || data_oe) seen = 1; end
        rd_n = 1'b0;
        for (int n = 0; n < 8; n++) begin @(negedge clk); if (req || rdy_oe || data_oe) seen = 1; end
        rd_n = 1'b1;
        for (int n = 0; n < 4; n++) begin @(negedge clk); if (req || rdy_oe || data_oe) seen = 1; end
        cs_n = 1'b1;
        check_eq({tag, " no activity"}, seen, 0);
        check_eq({tag, " no request counted"}, req_count, base);
    endtask

    task automatic test_reset();
        do_reset(2'b00);
        check_eq("R10 req after reset", req, 0);
        check_eq("R10 data_oe after reset", data_oe, 0);
        check_eq("R10 ready after reset", {rdy_oe, rdy_o}, 2'b01);
    endtask

    task automatic test_split();
        do_reset(2'b00);
        host_access(1, 0, 8'h12, 8'hA5, "split wr");
        host_access(1, 0, 8'hFE, 8'h3C, "split wr2");
        host_access(0, 0, 8'h12, 8'h00, "split rd");
        host_access(0, 0, 8'h40, 8'h00, "split rd untouched");
        quiet_strobes(0, "R2 deselected split");
    endtask

    task automatic test_latch();
        do_reset(2'b01);
        host_access(1, 1, 8'h81, 8'h5F, "latch wr");
        host_access(0, 1, 8'h81, 8'h00, "latch rd");
        host_access(1, 0, 8'h81, 8'h77, "R11 latch burst wr");
        // R2: latch pulse while deselected must leave the held address alone
        @(negedge clk);
        addr_in = 8'h5A; ale = 1'b1;
        repeat (4) @(negedge clk);
        ale = 1'b0;
        repeat (3) @(negedge clk);
        host_access(0, 0, 8'h81, 8'h00, "R2 deselected latch then R11 read");
    endtask

    task automatic test_shared();
        do_reset(2'b10);
        host_access(1, 1, 8'h2D, 8'hC3, "shared wr");
        host_access(1, 1, 8'hD2, 8'h0F, "shared wr2");
        host_access(0, 1, 8'h2D, 8'h00, "shared rd");
        host_access(0, 0, 8'h2D, 8'h00, "R11 shared burst rd");
    endtask

    task automatic test_off();
        do_reset(2'b11);
        quiet_strobes(1, "R1 port off");
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; data_in = 8'h99; addr_in = 8'h99;
        repeat (4) @(negedge clk);
        ale = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        check_eq("R1 no drive in port off", {req, data_oe, rdy_oe}, 3'b000);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            rf[i]      = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        test_reset();
        test_split();
        test_latch();
        test_shared();
        test_off();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule